// File: doc/BRIEF.md
# Branch Direction Predictor Unit

This unit gives a fetch stage a taken or not-taken guess for a conditional branch in the same cycle the branch is fetched. A two-bit mode input picks one of three policies. The first is a static rule: a branch that jumps backward is guessed taken, and one that jumps forward is guessed not taken. In this static policy a compiler-set hint bit can replace the sign rule. The second policy uses a table of one-bit entries, each holding the last outcome seen. The third uses a table of two-bit saturating counters.

Both tables are indexed by a slice of the fetch address and are read combinationally. A separate update port returns the resolved direction of a branch together with its address. Every update trains both tables, whichever policy is selected. Switching policy therefore never loses history. An address whose index bits match another's shares its entry; no tag is kept.

Top module: `bdp_top`

## Requirements
- R1: When `br_valid_i` is low, `pred_taken_o` is 0 in every mode.
- R2: In static mode (`mode_i` 2'b00, and 2'b11 which behaves the same) with `hint_en_i` low, `pred_taken_o` equals `disp_neg_i` (1 = backward displacement, so taken).
- R3: In static mode with `hint_en_i` high, `pred_taken_o` equals `hint_i` and `disp_neg_i` has no effect.
- R4: Both tables select their entry with address bits `[IDX_LSB +: IDX_W]`, which are bits [5:2] and 16 entries by default. Addresses that differ only outside those bits share an entry, and an update leaves every other entry unchanged.
- R5: In one-bit mode (`mode_i` 2'b01), the prediction equals the most recent resolved outcome written to the selected entry.
- R6: In two-bit mode (`mode_i` 2'b10), each entry is a counter with 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken and 3 = strong taken. A taken outcome increments it and a not-taken outcome decrements it, and it saturates at 0 and at 3. The prediction is the counter's upper bit.
- R7: An update sampled at a rising edge with `upd_valid_i` high becomes visible in the cycle after that edge. A lookup of the same entry in the cycle of the update returns the old value.
- R8: After reset, every one-bit entry holds not-taken and every two-bit entry holds weak not-taken (1).
- R9: Changing `mode_i` clears neither table. Updates train both tables in every mode, including the static mode and cycles with `br_valid_i` low.
- R10: In the two history modes, `hint_en_i`, `hint_i` and `disp_neg_i` have no effect on the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy select: 00 static, 01 one-bit table, 10 two-bit table, 11 static |
| hint_en_i | input | 1 | In static mode, use the hint bit instead of the displacement sign |
| br_valid_i | input | 1 | The fetched instruction is a conditional branch |
| fetch_pc_i | input | PC_W | Address of the fetched instruction |
| disp_neg_i | input | 1 | Sign of the branch displacement, 1 = backward |
| hint_i | input | 1 | Compiler direction hint, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch outcome is presented |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |

## Verification
The bench walks a counter from weak taken up into strong taken and back down past strong not-taken. A counter that wrapped instead of saturating would flip its guess after the extra taken or not-taken outcomes. A lookup that coincides with an update to the same entry must show the old value; a write-through design would show the new outcome one cycle early. Two addresses that alias in the index bits, and an update made while the static mode is selected and the branch flag is low, expose a design that tags entries, gates training on mode or clears tables on a mode change. A mid-run reset must bring the two-bit entries back to weak not-taken and not to zero: from zero, one taken outcome would fail to turn the guess to taken.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic [1:0] {
        MODE_STATIC     = 2'b00,
        MODE_LAST       = 2'b01,
        MODE_SAT        = 2'b10,
        MODE_STATIC_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // Saturating step of a two-bit direction counter.
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bdp_static.sv
module bdp_static (
    input  logic disp_neg_i,
    input  logic hint_i,
    input  logic hint_en_i,
    output logic taken_o
);
    always_comb begin
        if (hint_en_i) taken_o = hint_i;
        else           taken_o = disp_neg_i;
    end
endmodule

// File: rtl/bdp_hist1.sv
module bdp_hist1 #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_taken_i,
    output logic             rd_taken_o
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0] last;
    } h1_state_t;

    h1_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.last[wr_idx_i] = wr_taken_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_taken_o = st_q.last[rd_idx_i];
endmodule

// File: rtl/bdp_hist2.sv
module bdp_hist2
    import bdp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_taken_i,
    output logic             rd_taken_o
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } h2_state_t;

    h2_state_t st_d, st_q;
    h2_state_t st_rst;
    logic [1:0] rd_ctr;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) st_rst.ctr[e] = CTR_WNT;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i)
            st_d.ctr[wr_idx_i] = ctr_step(ctr_e'(st_q.ctr[wr_idx_i]), wr_taken_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign rd_ctr     = st_q.ctr[rd_idx_i];
    assign rd_taken_o = rd_ctr[1];
endmodule

// File: rtl/bdp_top.sv
module bdp_top
    import bdp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic            hint_en_i,
    input  logic            br_valid_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            disp_neg_i,
    input  logic            hint_i,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i,
    output logic            pred_taken_o
);
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             st_taken, h1_taken, h2_taken, pick;
    logic             unused_pc_bits;
    mode_e            mode;

    assign rd_idx = fetch_pc_i[IDX_LSB +: IDX_W];
    assign wr_idx = upd_pc_i[IDX_LSB +: IDX_W];
    assign unused_pc_bits = ^{fetch_pc_i, upd_pc_i};
    assign mode   = mode_e'(mode_i);

    bdp_static u_static (
        .disp_neg_i (disp_neg_i),
        .hint_i     (hint_i),
        .hint_en_i  (hint_en_i),
        .taken_o    (st_taken)
    );

    bdp_hist1 #(.IDX_W(IDX_W)) u_hist1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (rd_idx),
        .wr_en_i    (upd_valid_i),
        .wr_idx_i   (wr_idx),
        .wr_taken_i (upd_taken_i),
        .rd_taken_o (h1_taken)
    );

    bdp_hist2 #(.IDX_W(IDX_W)) u_hist2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (rd_idx),
        .wr_en_i    (upd_valid_i),
        .wr_idx_i   (wr_idx),
        .wr_taken_i (upd_taken_i),
        .rd_taken_o (h2_taken)
    );

    always_comb begin
        unique case (mode)
            MODE_LAST: pick = h1_taken;
            MODE_SAT:  pick = h2_taken;
            default:   pick = st_taken;
        endcase
    end

    assign pred_taken_o = br_valid_i & pick;
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode_i,
    input logic            hint_en_i,
    input logic            br_valid_i,
    input logic [PC_W-1:0] fetch_pc_i,
    input logic            disp_neg_i,
    input logic            hint_i,
    input logic            upd_valid_i,
    input logic [PC_W-1:0] upd_pc_i,
    input logic            upd_taken_i,
    input logic            pred_taken_o
);
    logic [IDX_W-1:0] f_idx, u_idx;
    logic             is_static;
    assign f_idx     = fetch_pc_i[IDX_LSB +: IDX_W];
    assign u_idx     = upd_pc_i[IDX_LSB +: IDX_W];
    assign is_static = (mode_i == 2'b00) || (mode_i == 2'b11);

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid_i |-> !pred_taken_o);

    p_sign_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && is_static && !hint_en_i) |-> (pred_taken_o == disp_neg_i));

    p_hint_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && is_static && hint_en_i) |-> (pred_taken_o == hint_i));

    // R5 and R7: the outcome written at an edge is what the next lookup sees.
    p_last_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> (!(mode_i == 2'b01 && br_valid_i && f_idx == $past(u_idx))
                         || (pred_taken_o == $past(upd_taken_i))));

    p_two_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_taken_i && $past(upd_valid_i && upd_taken_i)
         && u_idx == $past(u_idx))
        |=> (!(mode_i == 2'b10 && br_valid_i && f_idx == $past(u_idx)) || pred_taken_o));

    p_two_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && !upd_taken_i && $past(upd_valid_i && !upd_taken_i)
         && u_idx == $past(u_idx))
        |=> (!(mode_i == 2'b10 && br_valid_i && f_idx == $past(u_idx)) || !pred_taken_o));

    p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!(br_valid_i && (mode_i == 2'b01 || mode_i == 2'b10))
                          || !pred_taken_o));
endmodule

bind bdp_top bdp_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .hint_en_i    (hint_en_i),
    .br_valid_i   (br_valid_i),
    .fetch_pc_i   (fetch_pc_i),
    .disp_neg_i   (disp_neg_i),
    .hint_i       (hint_i),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .pred_taken_o (pred_taken_o)
);

// File: tb/bdp_top_tb.sv
module bdp_top_tb;
    localparam int PC_W = 32;
    localparam int NV   = 25;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      mode_i;
    logic            hint_en_i, br_valid_i, disp_neg_i, hint_i;
    logic [PC_W-1:0] fetch_pc_i, upd_pc_i;
    logic            upd_valid_i, upd_taken_i;
    logic            pred_taken_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bdp_top #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hint_en_i(hint_en_i),
        .br_valid_i(br_valid_i), .fetch_pc_i(fetch_pc_i), .disp_neg_i(disp_neg_i),
        .hint_i(hint_i), .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
        .upd_taken_i(upd_taken_i), .pred_taken_o(pred_taken_o)
    );

    // {mode, hint_en, valid, neg, hint, pc[7:0], upd_v, upd_t, upd_pc[7:0], expect, req}
    // Index = pc[5:2]: 8'h10 and 8'h50 both index 4, 8'h14 indexes 5.
    localparam logic [28:0] VEC [NV] = '{
        {2'd0,1'b0,1'b1,1'b1,1'b0,8'h10,1'b0,1'b0,8'h00,1'b1,4'd2},  // R2 backward
        {2'd0,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,1'b0,8'h00,1'b0,4'd2},  // R2 forward
        {2'd3,1'b0,1'b1,1'b1,1'b0,8'h10,1'b0,1'b0,8'h00,1'b1,4'd2},  // R2 mode 11
        {2'd0,1'b1,1'b1,1'b0,1'b1,8'h10,1'b0,1'b0,8'h00,1'b1,4'd3},  // R3 hint taken
        {2'd0,1'b1,1'b1,1'b1,1'b0,8'h10,1'b0,1'b0,8'h00,1'b0,4'd3},  // R3 hint not taken
        {2'd1,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,1'b0,8'h00,1'b0,4'd8},  // R8 one-bit
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,1'b0,8'h00,1'b0,4'd8},  // R8 two-bit
        {2'd0,1'b0,1'b0,1'b1,1'b0,8'h10,1'b1,1'b1,8'h10,1'b0,4'd1},  // R1, R9 train
        {2'd1,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b0,8'h10,1'b1,4'd7},  // R7 old value
        {2'd1,1'b0,1'b1,1'b0,1'b0,8'h50,1'b0,1'b0,8'h00,1'b0,4'd4},  // R4 alias, R5
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b1,8'h10,1'b0,4'd6},  // R6 ctr 1
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h50,1'b1,1'b1,8'h10,1'b1,4'd4},  // R4 alias ctr 2
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b1,8'h10,1'b1,4'd6},  // R6 ctr 3
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b0,8'h10,1'b1,4'd6},  // R6 held at 3
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b0,8'h10,1'b1,4'd6},  // R6 ctr 2
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b0,8'h10,1'b0,4'd6},  // R6 ctr 1
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b0,8'h10,1'b0,4'd6},  // R6 ctr 0
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b1,8'h10,1'b0,4'd6},  // R6 held at 0
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,1'b1,8'h10,1'b0,4'd6},  // R6 ctr 1
        {2'd2,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,1'b0,8'h00,1'b1,4'd6},  // R6 ctr 2
        {2'd1,1'b0,1'b1,1'b0,1'b0,8'h10,1'b0,1'b0,8'h00,1'b1,4'd9},  // R9 trained in 2-bit mode
        {2'd1,1'b0,1'b1,1'b0,1'b0,8'h14,1'b0,1'b0,8'h00,1'b0,4'd4},  // R4 other entry
        {2'd1,1'b1,1'b1,1'b1,1'b0,8'h10,1'b0,1'b0,8'h00,1'b1,4'd10}, // R10 one-bit
        {2'd2,1'b1,1'b1,1'b1,1'b1,8'h14,1'b0,1'b0,8'h00,1'b0,4'd10}, // R10 two-bit
        {2'd2,1'b0,1'b0,1'b0,1'b0,8'h10,1'b0,1'b0,8'h00,1'b0,4'd1}   // R1 history mode
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pred_taken_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic he, input logic v,
                         input logic n, input logic h, input logic [7:0] pc,
                         input logic uv, input logic ut, input logic [7:0] upc);
        mode_i = m; hint_en_i = he; br_valid_i = v; disp_neg_i = n; hint_i = h;
        fetch_pc_i = {{(PC_W-8){1'b0}}, pc};
        upd_valid_i = uv; upd_taken_i = ut;
        upd_pc_i = {{(PC_W-8){1'b0}}, upc};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 reset one-bit", pred_taken_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][28:27], VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23],
                  VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12:5]);
            #1;
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), pred_taken_o, VEC[i][4]);
        end

        // R4: highest index entry, taken outcome written, then looked up.
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h3C);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h00);
        #1;
        check("R4 index 15", pred_taken_o, 1'b1);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        #1;
        check("R4 index 0 untouched", pred_taken_o, 1'b0);

        // R8: mid-run reset restores both tables.
        @(negedge clk);
        rst_n = 1'b0;
        drive(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 two-bit after reset", pred_taken_o, 1'b0);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 8'h10);
        #1;
        check("R8 one-bit after reset", pred_taken_o, 1'b0);
        @(negedge clk);
        drive(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 8'h00);
        #1;
        check("R8 weak not-taken start, one taken", pred_taken_o, 1'b1);

        finish_run();
    end
endmodule